// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into framed characters on one serial output line. A seven-bit frame-control input sets the format of each frame: the data length (5 to 8 bits), the stop length, whether a parity bit is sent, and how that parity bit is formed. One bit of the same input forces a continuous break.

Bytes enter through a one-entry holding register with a valid/ready handshake. The shift engine takes a byte from the holding register whenever the engine is idle. While that byte is being shifted out, the holding register can accept the next byte. The engine is paced by an external oversampling tick. Each bit lasts `OS_RATIO` ticks, which is 16 by default, so a half stop bit lasts 8 ticks. The baud divisor that produces the tick sits outside this block.

The frame format is captured when a byte moves into the shift engine. The break bit is different: it acts at once. It aborts a frame that is in progress, and the next frame starts from the holding register once break is released.

Top module: `serial_tx`

## Requirements
- R1: `frame_ctrl[1:0]` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only that many low bits of the byte are sent.
- R2: With `frame_ctrl[2]`=0 the stop interval is one bit (16 ticks). With `frame_ctrl[2]`=1 it is 1.5 bits (24 ticks) for 5-bit data and 2 bits (32 ticks) for longer data.
- R3: With `frame_ctrl[3]`=1 and `frame_ctrl[5]`=0, one parity bit follows the last data bit and comes before the stop interval. It makes the count of ones even when `frame_ctrl[4]`=1 and odd when `frame_ctrl[4]`=0.
- R4: With `frame_ctrl[3]`=1 and `frame_ctrl[5]`=1, the parity bit is fixed: 0 when `frame_ctrl[4]`=1 and 1 when `frame_ctrl[4]`=0.
- R5: While `frame_ctrl[6]`=1, `txd` is low from the next clock on, whatever the shift engine was sending.
- R6: `hold_empty` is high whenever the holding register can take a byte, including while a frame is being shifted. `tx_empty` is high only when both the holding register and the shift engine are idle.
- R7: After a synchronous reset, `txd`, `hold_empty`, `tx_empty` and `wr_ready` are all high.
- R8: A byte is accepted on a clock where `wr_valid` and `wr_ready` are both high. `wr_ready` then stays low until the shift engine takes the byte.
- R9: The line idles high. Each frame starts with one low start bit, then sends the data least significant bit first. Every bit lasts 16 ticks.
- R10: A break that arrives during a frame aborts that frame. A byte that is waiting in the holding register stays there during the break and is sent as a complete new frame once the break is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_ctrl | input | 7 | Frame format and break control |
| os_tick | input | 1 | Oversampling tick, one clock wide, `OS_RATIO` per bit |
| wr_data | input | 8 | Byte to send |
| wr_valid | input | 1 | Byte offered |
| wr_ready | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Room for one more byte |
| tx_empty | output | 1 | Holding register and shift engine both idle |

## Verification
Break can assert in the same cycle in which the shift engine is in the middle of a data bit, and a second byte can be waiting in the holding register at that moment. The bench sets up this overlap in three steps. It starts a frame of all ones, queues a second byte, and then raises break partway through the data bits. The bench then checks that the line goes low at once and stays low throughout the break, even where a one would otherwise be sent. It also checks that the queued byte is still held and that, after release, that byte appears as a complete new frame with the correct bits.

// File: rtl/serial_tx_pkg.sv
// Shared types for the serial transmitter: shift-engine states and the
// frame format captured at the start of each frame.
package serial_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic       stick;   // fixed parity value
        logic       even;    // even parity / stick value select
        logic       pen;     // parity bit present
        logic       stop2;   // long stop interval
        logic [1:0] wlen;    // data length code, 0 -> 5 bits
    } frame_fmt_t;

    // Pull the format fields out of the control word (break excluded).
    function automatic frame_fmt_t decode_fmt(input logic [5:0] ctl);
        frame_fmt_t f;
        f.wlen  = ctl[1:0];
        f.stop2 = ctl[2];
        f.pen   = ctl[3];
        f.even  = ctl[4];
        f.stick = ctl[5];
        return f;
    endfunction

endpackage

// File: rtl/tx_hold.sv
// One-entry holding register. Accepts a byte on valid&ready. It releases the
// byte when the shift engine asserts pop. Assumes pop is raised only while full.
module tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          pop,
    output logic [DW-1:0] out_data,
    output logic          full
);

    logic accept;
    assign accept   = in_valid && !full;
    assign in_ready = !full;

    // Occupancy flag: set on accept, cleared when the engine takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (accept) full <= 1'b1;
        else if (pop)    full <= 1'b0;
    end

    // Data capture on accept only.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (accept) out_data <= in_data;
    end

endmodule

// File: rtl/tx_shift.sv
// Frame shift engine. Takes a byte from the holding register when idle and
// break is low, then sends start, data (LSB first), optional parity and the
// stop interval. Each bit lasts OS ticks, and a half bit lasts OS/2 ticks.
// The break input forces the line low and aborts any frame. Assumes OS is even.
module tx_shift
    import serial_tx_pkg::*;
#(
    parameter int DW = 8,
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  frame_fmt_t    fmt,
    input  logic          brk,
    input  logic          tick,
    input  logic          full,
    input  logic [DW-1:0] data,
    output logic          pop,
    output logic          idle,
    output logic          txd
);

    localparam int CW = $clog2(2 * OS) + 1;
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] LIM_ONE  = CW'(OS);
    localparam logic [CW-1:0] LIM_HALF = CW'(OS + OS / 2);
    localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OS);

    tx_state_e       state;
    frame_fmt_t      fmt_q;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   bit_idx;
    logic [DW-1:0]   sreg;
    logic            par_acc;
    logic [CW-1:0]   limit;
    logic [IW-1:0]   last_idx;
    logic            bit_done;
    logic            line_bit;
    logic            par_bit;

    assign idle     = (state == ST_IDLE);
    assign pop      = idle && full && !brk;
    assign last_idx = IW'({1'b0, fmt_q.wlen}) + IW'(4);

    // Tick count that closes the current bit (stop interval may be longer).
    always_comb begin
        limit = LIM_ONE;
        if (state == ST_STOP && fmt_q.stop2)
            limit = (fmt_q.wlen == 2'd0) ? LIM_HALF : LIM_TWO;
    end

    assign bit_done = tick && (cnt == limit - CW'(1));

    // Parity value: fixed in stick mode, else data parity adjusted for even/odd.
    assign par_bit = fmt_q.stick ? !fmt_q.even
                                 : (fmt_q.even ? par_acc : !par_acc);

    // Line level implied by the current state.
    always_comb begin
        unique case (state)
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = sreg[0];
            ST_PAR:   line_bit = par_bit;
            default:  line_bit = 1'b1;
        endcase
    end

    // Frame sequencer: load, tick counting, bit advance and break abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            sreg    <= '0;
            par_acc <= 1'b0;
            fmt_q   <= '0;
        end else if (brk) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (state == ST_IDLE) begin
            if (full) begin
                state   <= ST_START;
                sreg    <= data;
                fmt_q   <= fmt;
                cnt     <= '0;
                bit_idx <= '0;
                par_acc <= 1'b0;
            end
        end else if (tick) begin
            if (!bit_done) begin
                cnt <= cnt + CW'(1);
            end else begin
                cnt <= '0;
                unique case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        par_acc <= par_acc ^ sreg[0];
                        sreg    <= sreg >> 1;
                        if (bit_idx == last_idx)
                            state <= fmt_q.pen ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + IW'(1);
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Registered line output; break wins over any frame bit.
    always_ff @(posedge clk) begin
        if (!rst_n) txd <= 1'b1;
        else        txd <= brk ? 1'b0 : line_bit;
    end

endmodule

// File: rtl/serial_tx.sv
// Top of the configurable serial transmitter. It joins the holding register
// and the shift engine and derives the status flags. Assumes os_tick is
// one clock wide and arrives OS_RATIO times per bit.
module serial_tx
    import serial_tx_pkg::*;
#(
    parameter int OS_RATIO = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] frame_ctrl,
    input  logic       os_tick,
    input  logic [7:0] wr_data,
    input  logic       wr_valid,
    output logic       wr_ready,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    localparam int DW = 8;

    logic          pop;
    logic          full;
    logic          eng_idle;
    logic [DW-1:0] hold_data;
    frame_fmt_t    fmt;

    assign fmt = decode_fmt(frame_ctrl[5:0]);

    tx_hold #(.DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (wr_data),
        .in_valid (wr_valid),
        .in_ready (wr_ready),
        .pop      (pop),
        .out_data (hold_data),
        .full     (full)
    );

    tx_shift #(.DW(DW), .OS(OS_RATIO)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .fmt   (fmt),
        .brk   (frame_ctrl[6]),
        .tick  (os_tick),
        .full  (full),
        .data  (hold_data),
        .pop   (pop),
        .idle  (eng_idle),
        .txd   (txd)
    );

    assign hold_empty = !full;
    assign tx_empty   = !full && eng_idle;

endmodule

// File: rtl/serial_tx_chk.sv
// Checker for serial_tx, bound onto every instance. Port-level properties only.
module serial_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] frame_ctrl,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_empty
);

    // R5
    brk_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ctrl[6] |=> !txd);

    // R8
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    // R6
    empty_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    // R6
    pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !tx_empty);

    // R9
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && $past(tx_empty) && !$past(frame_ctrl[6])) |-> txd);

endmodule

bind serial_tx serial_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_ctrl (frame_ctrl),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/serial_tx_tb.sv
module serial_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TP = 4;              // clocks per oversampling tick
    localparam int BITC = 16 * TP;      // clocks per bit
    localparam int NV = 10;

    // {ctrl, data, expected parity bit, expected frame length in ticks}
    localparam logic [31:0] VEC [0:NV-1] = '{
        32'h03A5_00A0, 32'h0015_0070, 32'h040A_0078, 32'h073C_00B0,
        32'h1BA5_00B0, 32'h0BA5_01B0, 32'h2A7F_01A0, 32'h3A00_00A0,
        32'h09FF_0190, 32'h1D01_01A0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] frame_ctrl = 7'h03;
    logic       os_tick = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_valid = 1'b0;
    logic       wr_ready, txd, hold_empty, tx_empty;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .frame_ctrl(frame_ctrl), .os_tick(os_tick),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Tick source: one clock wide every TP clocks.
    initial begin
        forever begin
            repeat (TP - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_data  = d;
        wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_fall();
        int n = 0;
        while (txd && n < 4000) begin @(negedge clk); n++; end
    endtask

    // Samples each bit mid-period, starting from the start-bit edge.
    task automatic check_body(input logic [6:0] ctl, input logic [7:0] d,
                              input logic pexp);
        int nb = 5 + int'(ctl[1:0]);
        repeat (BITC / 2) @(negedge clk);
        check("R9", "start bit", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (BITC) @(negedge clk);
            check("R1", $sformatf("data bit %0d", i), int'(txd), int'(d[i]));
        end
        if (ctl[3]) begin
            repeat (BITC) @(negedge clk);
            check(ctl[5] ? "R4" : "R3", "parity bit", int'(txd), int'(pexp));
        end
        repeat (BITC) @(negedge clk);
        check("R9", "stop level", int'(txd), 1);
    endtask

    task automatic run_vec(input logic [31:0] v);
        logic [6:0] ctl = v[30:24];
        int t0, t1, dur, n;
        @(negedge clk);
        frame_ctrl = ctl;
        push(v[23:16]);
        wait_fall();
        t0 = cyc;
        check("R6", "hold_empty during shift", int'(hold_empty), 1);
        check("R6", "tx_empty during shift", int'(tx_empty), 0);
        check_body(ctl, v[23:16], v[8]);
        n = 0;
        while (!tx_empty && n < 4000) begin @(negedge clk); n++; end
        t1 = cyc;
        dur = t1 - t0;
        tests++;
        if (dur < int'(v[7:0]) * TP - TP || dur > int'(v[7:0]) * TP + TP) begin
            fails++;
            $display("FAIL R2 frame length actual=%0d expected=%0d cycles",
                     dur, int'(v[7:0]) * TP);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7", "txd in reset", int'(txd), 1);
        check("R7", "hold_empty in reset", int'(hold_empty), 1);
        check("R7", "tx_empty in reset", int'(tx_empty), 1);
        check("R7", "wr_ready in reset", int'(wr_ready), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", "idle line", int'(txd), 1);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R8/R6/R5/R10: break mid-frame with a byte waiting
        @(negedge clk);
        frame_ctrl = 7'h03;
        push(8'hFF);
        wait_fall();
        push(8'h81);
        check("R8", "wr_ready with byte held", int'(wr_ready), 0);
        check("R6", "hold_empty with byte held", int'(hold_empty), 0);
        repeat (BITC / 2 + 3 * BITC) @(negedge clk);
        frame_ctrl = 7'h43;
        repeat (2) @(negedge clk);
        check("R5", "break forces low", int'(txd), 0);
        repeat (40 * TP) @(negedge clk);
        check("R5", "break holds low", int'(txd), 0);
        check("R10", "held byte kept in break", int'(hold_empty), 0);
        check("R6", "tx_empty in break", int'(tx_empty), 0);
        frame_ctrl = 7'h03;
        check_body(7'h03, 8'h81, 1'b0);
        repeat (BITC) @(negedge clk);
        check("R10", "idle after resumed frame", int'(tx_empty), 1);
        check("R8", "ready after resumed frame", int'(wr_ready), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule